// File: doc/BRIEF.md
# Multi-Mode Programmable Timer Channel

This block is a single programmable timer channel. It holds a reload value and a down-counter, and it drives one output waveform. A 3-bit mode selects one of six output behaviours: a level that rises at terminal count, a one-shot that the gate can retrigger, a divide-by-N rate pulse, a square wave, and two single-clock strobes. One strobe is started by software loading a count, and the other is started by a gate edge. Every rising edge of `clk` is one count pulse.

A host first writes the mode through `mode_i` with `mode_wr_i`. It then presents a count on `load_val_i` with `load_i`. Depending on the mode, the `gate_i` input either enables counting while it is high, or triggers counting on its rising edge. The live counter value is always visible on `count_o`. A loaded value of zero stands for the full span, 2^CW.

Top module: `pit_chan`

## Requirements
- R1: After reset the selected mode is 0, `out_o` is low, `count_o` is 0 and the channel is stopped.
- R2: The cycle after `mode_wr_i`, `out_o` takes the idle level of the new mode. That level is low for mode 0 and high for every other mode. Counting stops and `count_o` holds until a new count is loaded. If `mode_wr_i` and `load_i` are both high in the same cycle, the mode write wins and the load is ignored.
- R3: Mode 0 (level at terminal count). On the load edge, the counter takes N and `out_o` goes low. `out_o` goes high on the N-th following edge, when the count reaches 0. `out_o` then stays high and the count holds at 0.
- R4: Mode 0. While `gate_i` is low the count holds. A new load during a count restarts the count from the new value with `out_o` low.
- R5: Mode 1 (one-shot). Loading does not start the count. A rising edge of `gate_i` loads N and drives `out_o` low on that edge. `out_o` returns high N edges later. Once triggered, the gate level does not pause the count.
- R6: Mode 1. A rising edge of `gate_i` during an active pulse reloads N. The low pulse then ends N edges after the retrigger.
- R7: Mode 2 (rate). The load starts the count with `out_o` high. With gate high, `out_o` is low for exactly one cycle in every N, on the (N-1)-th edge after each reload. The counter then reloads N by itself. N must be at least 2.
- R8: Mode 3 (square wave). After the load edge, `out_o` is high for ceil(N/2) cycles and low for floor(N/2) cycles, repeating with automatic reload. N must be at least 2.
- R9: Mode 4 (software strobe). The load starts the count with `out_o` high. `out_o` is low for exactly one cycle on the N-th gated edge after the load, and the count then stops at 0. While gate is low the count holds.
- R10: Mode 5 (hardware strobe). A load alone does not start the count. A rising edge of `gate_i` loads N. `out_o` is low for one cycle N edges later.
- R11: A loaded value of 0 counts as 2^CW. `count_o` reads 0 on the load edge, then 2^CW-1, and terminal count is reached after 2^CW edges.
- R12: Modes 2 and 3. While `gate_i` is low the count holds and `out_o` is forced high. A rising edge of `gate_i` restarts the count from N.
- R13: `mode_i` values 6 and 7 select the same behaviour as 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every rising edge is one count pulse |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Mode value captured by `mode_wr_i` |
| mode_wr_i | input | 1 | Mode write strobe |
| load_i | input | 1 | Count load strobe |
| load_val_i | input | CW (16) | Count value to load; 0 means 2^CW |
| gate_i | input | 1 | Gate: a level enable or a rising-edge trigger, depending on mode |
| out_o | output | 1 | Timer output waveform |
| count_o | output | CW (16) | Live counter value |

## Verification
The bench goes after the exact edge on which each waveform changes: the one-cycle low of the rate and strobe modes, the uneven halves of an odd square wave, and the edge where the one-shot returns high. A design that is one clock off in any of these shows a shifted or stretched pulse at a sampled cycle.

Retriggering the one-shot mid-pulse catches a design that ignores the second edge, which would end the pulse early. Pausing the gate in modes 0, 2 and 4 catches a design that keeps counting, or that leaves the output low in modes 2 and 3. Loading zero catches a counter that treats 0 as an instant terminal count instead of the full span.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

   typedef enum logic [2:0] {
      M_TC_LEVEL  = 3'd0,
      M_ONESHOT   = 3'd1,
      M_RATE      = 3'd2,
      M_SQUARE    = 3'd3,
      M_SW_STROBE = 3'd4,
      M_HW_STROBE = 3'd5
   } chan_mode_e;

   // Values 6 and 7 alias the rate and square modes.
   function automatic chan_mode_e decode_mode(input logic [2:0] raw);
      if (raw[1]) return chan_mode_e'({1'b0, raw[1:0]});
      return chan_mode_e'(raw);
   endfunction

   // Idle output level after a mode write: low only for mode 0.
   function automatic logic idle_level(input chan_mode_e m);
      return (m != M_TC_LEVEL);
   endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   output logic level_o,
   output logic rise_o
);
   logic level_q;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_cfg
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign level_o = gate_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else if (s == 0) chain_q[s] <= gate_i;
               else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
         end
         assign level_o = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   // Reset the history high so a gate already high at reset is not a trigger.
   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b1;
      else        level_q <= level_o;
   end

   assign rise_o = level_o & ~level_q;
endmodule

// File: rtl/pit_count_reg.sv
module pit_count_reg #(
   parameter int CW = 16,
   localparam int CNTW = CW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_wr_i,
   input  logic            load_i,
   input  logic [CW-1:0]   load_val_i,
   output logic [CNTW-1:0] fresh_o,
   output logic [CNTW-1:0] held_o,
   output logic            valid_o,
   output logic            armed_o
);
   localparam logic [CNTW-1:0] FULL_SPAN = CNTW'(1) << CW;

   logic [CNTW-1:0] held_q;
   logic            valid_q;

   assign fresh_o = (load_val_i == '0) ? FULL_SPAN : {1'b0, load_val_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q  <= '0;
         valid_q <= 1'b0;
      end else if (mode_wr_i) begin
         valid_q <= 1'b0;
      end else if (load_i) begin
         held_q  <= fresh_o;
         valid_q <= 1'b1;
      end
   end

   assign held_o  = held_q;
   assign valid_o = valid_q;
   assign armed_o = valid_q | (load_i & ~mode_wr_i);

   a_r11_zero_span: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !mode_wr_i && load_val_i == '0) |=> held_q == FULL_SPAN);
endmodule

// File: rtl/pit_chan_core.sv
module pit_chan_core
   import pit_chan_pkg::*;
#(
   parameter int CW = 16,
   localparam int CNTW = CW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  chan_mode_e      mode_q_i,
   input  chan_mode_e      mode_new_i,
   input  logic            mode_wr_i,
   input  logic            load_i,
   input  logic            gate_lvl_i,
   input  logic            gate_rise_i,
   input  logic            armed_i,
   input  logic [CNTW-1:0] fresh_i,
   input  logic [CNTW-1:0] held_i,
   output logic            out_o,
   output logic [CNTW-1:0] cnt_o
);
   logic [CNTW-1:0] cnt_q, src, hi_half, lo_half;
   logic            run_q, out_q, at_end, trig;

   assign src     = load_i ? fresh_i : held_i;
   assign hi_half = (src >> 1) + {{CW{1'b0}}, src[0]};
   assign lo_half = src >> 1;
   assign at_end  = (cnt_q <= CNTW'(1));
   assign trig    = gate_rise_i & armed_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         out_q <= 1'b0;
      end else if (mode_wr_i) begin
         run_q <= 1'b0;
         out_q <= idle_level(mode_new_i);
      end else begin
         unique case (mode_q_i)
            M_TC_LEVEL: begin
               if (load_i) begin
                  cnt_q <= fresh_i; run_q <= 1'b1; out_q <= 1'b0;
               end else if (run_q && gate_lvl_i) begin
                  if (at_end) begin
                     cnt_q <= '0; run_q <= 1'b0; out_q <= 1'b1;
                  end else cnt_q <= cnt_q - 1'b1;
               end
            end
            M_ONESHOT: begin
               if (trig) begin
                  cnt_q <= src; run_q <= 1'b1; out_q <= 1'b0;
               end else if (run_q) begin
                  if (at_end) begin
                     cnt_q <= '0; run_q <= 1'b0; out_q <= 1'b1;
                  end else cnt_q <= cnt_q - 1'b1;
               end
            end
            M_RATE: begin
               if ((load_i && !run_q) || (trig && gate_lvl_i)) begin
                  cnt_q <= src; run_q <= 1'b1; out_q <= 1'b1;
               end else if (!gate_lvl_i) begin
                  out_q <= 1'b1;
               end else if (run_q) begin
                  if (at_end) begin
                     cnt_q <= src; out_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                     out_q <= (cnt_q != CNTW'(2));
                  end
               end
            end
            M_SQUARE: begin
               if ((load_i && !run_q) || (trig && gate_lvl_i)) begin
                  cnt_q <= hi_half; run_q <= 1'b1; out_q <= 1'b1;
               end else if (!gate_lvl_i) begin
                  out_q <= 1'b1;
               end else if (run_q) begin
                  if (at_end) begin
                     cnt_q <= out_q ? lo_half : hi_half;
                     out_q <= ~out_q;
                  end else cnt_q <= cnt_q - 1'b1;
               end
            end
            M_SW_STROBE: begin
               if (load_i) begin
                  cnt_q <= fresh_i; run_q <= 1'b1; out_q <= 1'b1;
               end else if (!out_q) begin
                  out_q <= 1'b1;
               end else if (run_q && gate_lvl_i) begin
                  if (at_end) begin
                     cnt_q <= '0; run_q <= 1'b0; out_q <= 1'b0;
                  end else cnt_q <= cnt_q - 1'b1;
               end
            end
            M_HW_STROBE: begin
               if (trig) begin
                  cnt_q <= src; run_q <= 1'b1; out_q <= 1'b1;
               end else if (!out_q) begin
                  out_q <= 1'b1;
               end else if (run_q) begin
                  if (at_end) begin
                     cnt_q <= '0; run_q <= 1'b0; out_q <= 1'b0;
                  end else cnt_q <= cnt_q - 1'b1;
               end
            end
            default: run_q <= 1'b0;
         endcase
      end
   end

   assign out_o = out_q;
   assign cnt_o = cnt_q;

   a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr_i |=> out_q == (decode_mode($past(mode_new_i)) != M_TC_LEVEL));
   a_r3_tc_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q_i == M_TC_LEVEL && out_q && !load_i && !mode_wr_i) |=> out_q);
   a_r4_gate_pause: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q_i == M_TC_LEVEL && !gate_lvl_i && !load_i && !mode_wr_i) |=> $stable(cnt_q));
   a_r7_rate_single_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q_i == M_RATE && !out_q && !mode_wr_i) |=> out_q);
   a_r9_strobe_single_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q_i == M_SW_STROBE || mode_q_i == M_HW_STROBE) && !out_q && !mode_wr_i) |=> out_q);
endmodule

// File: rtl/pit_chan.sv
module pit_chan
   import pit_chan_pkg::*;
#(
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    mode_i,
   input  logic          mode_wr_i,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          gate_i,
   output logic          out_o,
   output logic [CW-1:0] count_o
);
   localparam int CNTW = CW + 1;

   generate
      if (CW < 2 || CW > 32) begin : g_bad_width
         $error("CW must lie between 2 and 32");
      end
   endgenerate

   chan_mode_e      mode_q, mode_new;
   logic            gate_lvl, gate_rise, armed, valid;
   logic [CNTW-1:0] fresh, held, cnt;

   assign mode_new = decode_mode(mode_i);

   always_ff @(posedge clk) begin
      if (!rst_n)         mode_q <= M_TC_LEVEL;
      else if (mode_wr_i) mode_q <= mode_new;
   end

   pit_gate_edge #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i),
      .level_o(gate_lvl), .rise_o(gate_rise)
   );

   pit_count_reg #(.CW(CW)) u_reload (
      .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr_i), .load_i(load_i),
      .load_val_i(load_val_i), .fresh_o(fresh), .held_o(held),
      .valid_o(valid), .armed_o(armed)
   );

   pit_chan_core #(.CW(CW)) u_core (
      .clk(clk), .rst_n(rst_n), .mode_q_i(mode_q), .mode_new_i(mode_new),
      .mode_wr_i(mode_wr_i), .load_i(load_i), .gate_lvl_i(gate_lvl),
      .gate_rise_i(gate_rise), .armed_i(armed), .fresh_i(fresh),
      .held_i(held), .out_o(out_o), .cnt_o(cnt)
   );

   assign count_o = cnt[CW-1:0];

   a_r5_oneshot_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_ONESHOT && !valid && !load_i && !mode_wr_i && out_o) |=> out_o);
endmodule

// File: tb/pit_chan_bench.sv
`timescale 1ns/1ps
module pit_chan_bench;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode_i = '0;
   logic          mode_wr_i = 1'b0;
   logic          load_i = 1'b0;
   logic [CW-1:0] load_val_i = '0;
   logic          gate_i = 1'b0;
   logic          out_o;
   logic [CW-1:0] count_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pit_chan #(.CW(CW)) u_pit_chan (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_wr_i(mode_wr_i),
      .load_i(load_i), .load_val_i(load_val_i), .gate_i(gate_i),
      .out_o(out_o), .count_o(count_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr_mode(input logic [2:0] m);
      mode_i = m; mode_wr_i = 1'b1; tick(1); mode_wr_i = 1'b0;
   endtask

   task automatic do_load(input logic [CW-1:0] v);
      load_val_i = v; load_i = 1'b1; tick(1); load_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "out after reset", out_o, 0);
      chk("R1", "count after reset", count_o, 0);
   endtask

   task automatic t_mode0();
      gate_i = 1'b1;
      wr_mode(3'd0);
      chk("R2", "mode0 idle out", out_o, 0);
      do_load(16'd5);
      chk("R3", "count on load", count_o, 5);
      chk("R3", "out low on load", out_o, 0);
      tick(4);
      chk("R3", "out before terminal", out_o, 0);
      chk("R3", "count before terminal", count_o, 1);
      tick(1);
      chk("R3", "out at terminal", out_o, 1);
      tick(3);
      chk("R3", "out latched high", out_o, 1);
      chk("R3", "count held at zero", count_o, 0);
      do_load(16'd6);
      tick(2);
      gate_i = 1'b0;
      tick(2);
      chk("R4", "count held with gate low", count_o, 4);
      gate_i = 1'b1;
      tick(1);
      chk("R4", "count resumes", count_o, 3);
      do_load(16'd9);
      chk("R4", "reload restarts count", count_o, 9);
      chk("R4", "reload keeps out low", out_o, 0);
      // mode write and load together: the write wins
      mode_i = 3'd0; mode_wr_i = 1'b1; load_val_i = 16'd3; load_i = 1'b1;
      tick(1);
      mode_wr_i = 1'b0; load_i = 1'b0;
      tick(3);
      chk("R2", "count stopped by mode write", count_o, 9);
      chk("R2", "out idle in mode0", out_o, 0);
      wr_mode(3'd2);
      chk("R2", "out idle high in mode2", out_o, 1);
   endtask

   task automatic t_mode1();
      gate_i = 1'b0;
      wr_mode(3'd1);
      chk("R2", "mode1 idle out", out_o, 1);
      do_load(16'd4);
      tick(2);
      chk("R5", "no start without trigger", out_o, 1);
      gate_i = 1'b1;
      tick(1);
      chk("R5", "out low on trigger", out_o, 0);
      chk("R5", "count on trigger", count_o, 4);
      gate_i = 1'b0;
      tick(3);
      chk("R5", "out low before end", out_o, 0);
      tick(1);
      chk("R5", "out high after N", out_o, 1);
      gate_i = 1'b1;
      tick(1);
      tick(1);
      gate_i = 1'b0;
      tick(1);
      gate_i = 1'b1;
      tick(1);
      chk("R6", "retrigger reloads", count_o, 4);
      chk("R6", "pulse still low", out_o, 0);
      tick(3);
      chk("R6", "pulse extended", out_o, 0);
      tick(1);
      chk("R6", "pulse ends N after retrigger", out_o, 1);
   endtask

   task automatic t_mode2();
      gate_i = 1'b1;
      wr_mode(3'd2);
      do_load(16'd4);
      chk("R7", "out high on load", out_o, 1);
      for (int i = 1; i <= 8; i++) begin
         tick(1);
         chk("R7", $sformatf("rate out at edge %0d", i), out_o, (i % 4 != 3) ? 1 : 0);
      end
      tick(1);
      gate_i = 1'b0;
      tick(2);
      chk("R12", "rate count held", count_o, 3);
      chk("R12", "rate out forced high", out_o, 1);
      gate_i = 1'b1;
      tick(1);
      chk("R12", "rate gate rise reloads", count_o, 4);
      wr_mode(3'd6);
      do_load(16'd3);
      chk("R13", "alias load count", count_o, 3);
      for (int i = 1; i <= 3; i++) begin
         tick(1);
         chk("R13", $sformatf("alias rate out at edge %0d", i), out_o, (i % 3 != 2) ? 1 : 0);
      end
   endtask

   task automatic t_mode3();
      gate_i = 1'b1;
      wr_mode(3'd3);
      do_load(16'd5);
      chk("R8", "odd square out at load", out_o, 1);
      for (int i = 1; i <= 10; i++) begin
         tick(1);
         chk("R8", $sformatf("odd square out at edge %0d", i), out_o, (i % 5 < 3) ? 1 : 0);
      end
      wr_mode(3'd3);
      do_load(16'd4);
      for (int i = 1; i <= 8; i++) begin
         tick(1);
         chk("R8", $sformatf("even square out at edge %0d", i), out_o, (i % 4 < 2) ? 1 : 0);
      end
      gate_i = 1'b0;
      tick(1);
      chk("R12", "square out forced high", out_o, 1);
   endtask

   task automatic t_mode4();
      gate_i = 1'b1;
      wr_mode(3'd4);
      do_load(16'd3);
      chk("R9", "strobe out high on load", out_o, 1);
      tick(2);
      chk("R9", "strobe out before terminal", out_o, 1);
      tick(1);
      chk("R9", "strobe low at N", out_o, 0);
      tick(1);
      chk("R9", "strobe one cycle", out_o, 1);
      chk("R9", "count stops at zero", count_o, 0);
      do_load(16'd3);
      gate_i = 1'b0;
      tick(3);
      chk("R9", "strobe count held", count_o, 3);
      chk("R9", "strobe no pulse while held", out_o, 1);
   endtask

   task automatic t_mode5();
      int c;
      gate_i = 1'b0;
      wr_mode(3'd5);
      do_load(16'd3);
      c = int'(count_o);
      tick(2);
      chk("R10", "no start on load alone", int'(count_o), c);
      chk("R10", "out high before trigger", out_o, 1);
      gate_i = 1'b1;
      tick(1);
      chk("R10", "count on gate edge", count_o, 3);
      tick(2);
      chk("R10", "out high before terminal", out_o, 1);
      tick(1);
      chk("R10", "strobe low at N", out_o, 0);
      tick(1);
      chk("R10", "strobe one cycle", out_o, 1);
   endtask

   task automatic t_zero();
      gate_i = 1'b1;
      wr_mode(3'd0);
      do_load(16'd0);
      chk("R11", "zero load reads 0", count_o, 0);
      tick(1);
      chk("R11", "zero load wraps to max", count_o, 65535);
      tick(65534);
      chk("R11", "out low before full span", out_o, 0);
      chk("R11", "count one before end", count_o, 1);
      tick(1);
      chk("R11", "out high after full span", out_o, 1);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      t_reset();
      t_mode0();
      t_mode1();
      t_mode2();
      t_mode3();
      t_mode4();
      t_mode5();
      t_zero();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule